// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block is a small cache between a CPU request stream and a byte-wide backing memory of sixteen 16-byte blocks. It holds eight 16-byte lines arranged as four sets of two ways. A request names a block number and a byte offset and, for a store, a value. Each line keeps a valid flag and a tag. The tag is the complete block number, not just its upper bits. A store always updates memory as well as the cache. A store that misses first brings the block into the cache.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream. The request side takes one command at a time. It lowers `req_ready` from the moment a command is accepted until that command's result has been handed over. Holding `req_valid` high while `req_ready` is low is legal, and the command waits. The response side holds its data and hit flag steady until `rsp_ready` is seen high. The memory port is plain: the address is a combinational output and the read data is a combinational input. `mem_we` writes on the rising edge. Four counters report hits and misses, kept apart for loads and stores.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, all four counters read 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A block goes to set (block mod 4). It hits only when a valid way of that set holds a tag equal to the full block number, so blocks 0 and 4 never alias.
- R3: A read hit returns the cached byte with `rsp_hit`=1 and adds one to the read-hit counter.
- R4: A read miss copies all 16 bytes of the block from memory into one line, then returns the requested byte with `rsp_hit`=0 and adds one to the read-miss counter. Later reads of any offset of that block hit.
- R5: On a miss, the line refilled is the lowest-numbered invalid way of the set. If both ways are valid, the way is bit 0 of an 8-bit LFSR. The LFSR has seed 0x01 and shifts left, with the XOR of bits 7, 5, 4 and 3 entering bit 0. It steps exactly once per such forced replacement and at no other time.
- R6: A write hit updates the cached byte and drives exactly one `mem_we` cycle at address block*16+offset with the new value. It returns that value with `rsp_hit`=1 and adds one to the write-hit counter.
- R7: A write miss adds one to the write-miss counter only, fills the line as in R4, and then writes the byte to the line and to memory with one `mem_we` cycle. It returns the value with `rsp_hit`=0.
- R8: `req_ready` is high only when no command is in progress. It stays low for at least 18 clock edges after a command that misses is accepted.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_hit` hold their values.
- R10: Each command changes exactly one counter, by exactly one.
- R11: A third block mapped to a full set evicts the way chosen by R5, and the evicted block misses on its next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_block | input | 4 | Memory block number |
| req_offset | input | 4 | Byte offset inside the block |
| req_wdata | input | 8 | Store value |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle |
| rsp_rdata | output | 8 | Loaded byte, or stored value for a store |
| rsp_hit | output | 1 | 1 if the command hit |
| mem_addr | output | 8 | Backing memory byte address |
| mem_rdata | input | 8 | Backing memory read data (combinational) |
| mem_we | output | 1 | Backing memory write strobe |
| mem_wdata | output | 8 | Backing memory write data |
| rd_hit_cnt | output | 16 | Read hits |
| rd_miss_cnt | output | 16 | Read misses |
| wr_hit_cnt | output | 16 | Write hits |
| wr_miss_cnt | output | 16 | Write misses |

## Verification
A corrupted tag or valid bit shows up at the next access to that set. It gives a wrong `rsp_hit` flag and moves one count between a hit counter and a miss counter, one command later at most. A wrong victim way or LFSR step can stay hidden for a while. It appears only when the evicted block is touched again and then hits or misses against the mirrored prediction. A fill that stores a byte in the wrong place, or a missing write-through, appears as a wrong `rsp_rdata` on a later read of that byte. It also appears in the final comparison of the bench memory against the model's memory.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_RESP} cache_state_e;
  localparam int          RNG_W    = 8;
  localparam logic [7:0]  RNG_TAPS = 8'hB8;
  localparam logic [7:0]  RNG_SEED = 8'h01;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[W-2:0], ^(state & TAPS)};
  end
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
)(
  input  logic [WAYS-1:0]  way_valid,
  input  logic [TAG_W-1:0] way_tag [WAYS],
  input  logic [TAG_W-1:0] want_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             free_any,
  output logic [WAY_W-1:0] free_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == want_tag);
  end

  // descending scan so the lowest index wins
  always_comb begin
    hit      = |match;
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
      if (!way_valid[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
  parameter int CNT_W = 16,
  parameter int N     = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     bump,
  output logic [CNT_W-1:0] count [N]
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count[i] <= '0;
      else if (bump[i]) count[i] <= count[i] + 1'b1;
    end
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import cache_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int WAYS      = 2,
  parameter int BLOCKS    = 16,
  parameter int BLK_BYTES = 16,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16
)(
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          req_valid,
  output logic                                          req_ready,
  input  logic                                          req_write,
  input  logic [$clog2(BLOCKS)-1:0]                     req_block,
  input  logic [$clog2(BLK_BYTES)-1:0]                  req_offset,
  input  logic [DATA_W-1:0]                             req_wdata,
  output logic                                          rsp_valid,
  input  logic                                          rsp_ready,
  output logic [DATA_W-1:0]                             rsp_rdata,
  output logic                                          rsp_hit,
  output logic [$clog2(BLOCKS)+$clog2(BLK_BYTES)-1:0]   mem_addr,
  input  logic [DATA_W-1:0]                             mem_rdata,
  output logic                                          mem_we,
  output logic [DATA_W-1:0]                             mem_wdata,
  output logic [CNT_W-1:0]                              rd_hit_cnt,
  output logic [CNT_W-1:0]                              rd_miss_cnt,
  output logic [CNT_W-1:0]                              wr_hit_cnt,
  output logic [CNT_W-1:0]                              wr_miss_cnt
);
  localparam int BLK_W  = $clog2(BLOCKS);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int SETS   = LINES / WAYS;
  localparam int SET_W  = (SETS > 1)  ? $clog2(SETS)  : 1;
  localparam int WAY_W  = (WAYS > 1)  ? $clog2(WAYS)  : 1;
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

  cache_state_e      state_q;
  logic              wr_q, filled_q, rsp_hit_q;
  logic [BLK_W-1:0]  blk_q;
  logic [OFF_W-1:0]  off_q, beat_q;
  logic [DATA_W-1:0] wdata_q, rsp_data_q;
  logic [WAY_W-1:0]  fill_way_q;
  logic [LINES-1:0]  valid_q;
  logic [BLK_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES][BLK_BYTES];

  function automatic logic [LINE_W-1:0] line_of(input logic [SET_W-1:0] s, input int w);
    return LINE_W'(32'(s) * WAYS + w);
  endfunction

  // set selection: block number modulo set count
  logic [SET_W-1:0] set_idx;
  assign set_idx = SET_W'(32'(blk_q) % SETS);

  logic [WAYS-1:0]  set_valid;
  logic [BLK_W-1:0] set_tag [WAYS];
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_q[line_of(set_idx, w)];
      set_tag[w]   = tag_q[line_of(set_idx, w)];
    end
  end

  logic             hit, free_any;
  logic [WAY_W-1:0] hit_way, free_way, rand_way, victim_way;
  logic [RNG_W-1:0] rng;

  cache_lookup #(.WAYS(WAYS), .TAG_W(BLK_W), .WAY_W(WAY_W)) u_lookup (
    .way_valid(set_valid), .way_tag(set_tag), .want_tag(blk_q),
    .hit(hit), .hit_way(hit_way), .free_any(free_any), .free_way(free_way)
  );

  logic look, look_miss, write_hit, fill_last;
  assign look      = (state_q == ST_LOOK);
  assign look_miss = look && !hit;
  assign write_hit = look && hit && wr_q;
  assign fill_last = (state_q == ST_FILL) && (beat_q == OFF_W'(BLK_BYTES - 1));

  cache_lfsr #(.W(RNG_W), .TAPS(RNG_TAPS), .SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst_n(rst_n), .step(look_miss && !free_any), .state(rng)
  );

  if (WAYS == 1) begin : g_dm
    assign rand_way = '0;
  end else begin : g_assoc
    assign rand_way = rng[WAY_W-1:0];
  end
  assign victim_way = free_any ? free_way : rand_way;

  logic [LINE_W-1:0] hit_line, fill_line, victim_line;
  assign hit_line    = line_of(set_idx, int'(hit_way));
  assign fill_line   = line_of(set_idx, int'(fill_way_q));
  assign victim_line = line_of(set_idx, int'(victim_way));

  // control and valid state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      valid_q    <= '0;
      filled_q   <= 1'b0;
      wr_q       <= 1'b0;
      blk_q      <= '0;
      off_q      <= '0;
      wdata_q    <= '0;
      beat_q     <= '0;
      fill_way_q <= '0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          blk_q    <= req_block;
          off_q    <= req_offset;
          wdata_q  <= req_wdata;
          filled_q <= 1'b0;
          state_q  <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          rsp_data_q <= wr_q ? wdata_q : data_q[hit_line][off_q];
          rsp_hit_q  <= !filled_q;
          state_q    <= ST_RESP;
        end else begin
          fill_way_q           <= victim_way;
          beat_q               <= '0;
          valid_q[victim_line] <= 1'b0;
          state_q              <= ST_FILL;
        end
        ST_FILL: begin
          beat_q <= beat_q + 1'b1;
          if (fill_last) begin
            valid_q[fill_line] <= 1'b1;
            filled_q           <= 1'b1;
            state_q            <= ST_LOOK;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage: no reset, guarded by valid_q
  always_ff @(posedge clk) begin
    if (look_miss) tag_q[victim_line] <= blk_q;
    if (state_q == ST_FILL) data_q[fill_line][beat_q] <= mem_rdata;
    if (write_hit) data_q[hit_line][off_q] <= wdata_q;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_hit   = rsp_hit_q;
  assign mem_addr  = {blk_q, (state_q == ST_FILL) ? beat_q : off_q};
  assign mem_we    = write_hit;
  assign mem_wdata = wdata_q;

  // counters: only the first lookup of a command is counted
  logic             first_look;
  logic [3:0]       bump;
  logic [CNT_W-1:0] cnt [4];
  assign first_look = look && !filled_q;
  assign bump = {first_look && !hit &&  wr_q,
                 first_look &&  hit &&  wr_q,
                 first_look && !hit && !wr_q,
                 first_look &&  hit && !wr_q};

  cache_stats #(.CNT_W(CNT_W), .N(4)) u_stats (
    .clk(clk), .rst_n(rst_n), .bump(bump), .count(cnt)
  );
  assign rd_hit_cnt  = cnt[0];
  assign rd_miss_cnt = cnt[1];
  assign wr_hit_cnt  = cnt[2];
  assign wr_miss_cnt = cnt[3];
endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_hit,
  input logic              mem_we,
  input logic [CNT_W-1:0]  rd_hit_cnt,
  input logic [CNT_W-1:0]  rd_miss_cnt,
  input logic [CNT_W-1:0]  wr_hit_cnt,
  input logic [CNT_W-1:0]  wr_miss_cnt
);
  logic [CNT_W+1:0] total;
  assign total = (CNT_W+2)'(rd_hit_cnt) + (CNT_W+2)'(rd_miss_cnt)
               + (CNT_W+2)'(wr_hit_cnt) + (CNT_W+2)'(wr_miss_cnt);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid && total == '0);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit));

  a_r8_busy_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r6_write_inside_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready && !rsp_valid);

  a_r10_single_count: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (total - $past(total)) <= 1);
endmodule

bind wt_cache cache_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_hit(rsp_hit), .mem_we(mem_we), .rd_hit_cnt(rd_hit_cnt),
  .rd_miss_cnt(rd_miss_cnt), .wr_hit_cnt(wr_hit_cnt), .wr_miss_cnt(wr_miss_cnt)
);

// File: tb/wt_cache_bench.sv
module wt_cache_bench;
  localparam int SETS = 4, WAYS = 2, LINES = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [3:0] req_block = 0, req_offset = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_hit, mem_we;
  logic [7:0] rsp_rdata, mem_addr, mem_rdata, mem_wdata;
  logic [15:0] rd_hit_cnt, rd_miss_cnt, wr_hit_cnt, wr_miss_cnt;

  always #5 clk = ~clk;

  wt_cache u_wt_cache (.*);

  // backing memory
  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr];
  int we_seen = 0;
  always @(posedge clk) if (rst_n && mem_we) begin
    mem[mem_addr] <= mem_wdata;
    we_seen <= we_seen + 1;
  end

  // reference model
  logic [7:0] model_mem [256];
  bit         m_valid [LINES];
  int         m_tag   [LINES];
  logic [7:0] m_lfsr = 8'h01;
  int m_rh = 0, m_rm = 0, m_wh = 0, m_wm = 0, m_writes = 0;
  int nchk = 0, nfail = 0, waited = 0;

  logic [8:0] exp_q [$];
  string      rq_q  [$];

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input int blk, input int off, input logic [7:0] val, input string rq);
    int set, line, way;
    bit hit;
    logic [7:0] exp;
    set = blk % SETS; hit = 0; line = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[set*WAYS+w] && m_tag[set*WAYS+w] == blk) begin hit = 1; line = set*WAYS+w; end
    if (!hit) begin
      way = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[set*WAYS+w]) way = w;
      if (way < 0) begin
        way = int'(m_lfsr) % WAYS;
        m_lfsr = {m_lfsr[6:0], ^(m_lfsr & 8'hB8)};
      end
      line = set*WAYS + way;
      m_valid[line] = 1; m_tag[line] = blk;
      if (wr) m_wm++; else m_rm++;
    end else if (wr) m_wh++; else m_rh++;
    if (wr) begin model_mem[blk*16+off] = val; exp = val; m_writes++; end
    else exp = model_mem[blk*16+off];
    exp_q.push_back({hit, exp});
    rq_q.push_back(rq);
    req_valid = 1; req_write = wr; req_block = 4'(blk); req_offset = 4'(off); req_wdata = val;
    waited = 0;
    while (!req_ready) begin @(negedge clk); waited++; end
    @(negedge clk);
    req_valid = 0;
  endtask

  // scoreboard monitor with response back-pressure
  initial begin
    bit held = 0;
    logic [7:0] hd = 0;
    logic hh = 0;
    int ncyc = 0;
    logic [8:0] e;
    string r;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (held) begin
        check(rsp_valid === 1'b1 && rsp_rdata === hd && rsp_hit === hh, "R9", "held response",
              int'({rsp_hit, rsp_rdata}), int'({hh, hd}));
      end
      ncyc++;
      rsp_ready = (ncyc % 5) >= 2;
      held = rsp_valid && !rsp_ready;
      hd = rsp_rdata; hh = rsp_hit;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(0, "R8", "unexpected response", 1, 0);
        else begin
          e = exp_q.pop_front();
          r = rq_q.pop_front();
          check(rsp_hit === e[8], r, "rsp_hit", int'(rsp_hit), int'(e[8]));
          check(rsp_rdata === e[7:0], r, "rsp_rdata", int'(rsp_rdata), int'(e[7:0]));
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int bad;
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'((a * 7 + 3) & 8'hFF);
      model_mem[a] = mem[a];
    end
    for (int l = 0; l < LINES; l++) begin m_valid[l] = 0; m_tag[l] = -1; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1, "R1", "req_ready", int'(req_ready), 1);
    check(rsp_valid === 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    check(rd_hit_cnt + rd_miss_cnt + wr_hit_cnt + wr_miss_cnt === 16'd0, "R1", "counters",
          int'(rd_hit_cnt + rd_miss_cnt + wr_hit_cnt + wr_miss_cnt), 0);

    // R4 miss then R3 hits at other offsets
    issue(0, 3, 2, 0, "R4");
    issue(0, 3, 2, 0, "R3");
    check(waited >= 18, "R8", "ready-low edges after miss", waited, 18);
    issue(0, 3, 15, 0, "R3");
    issue(0, 3, 0, 0, "R4");

    // R7 write miss, then R6 write hit, then reads of the new data
    issue(1, 4, 1, 8'hAA, "R7");
    issue(0, 4, 1, 0, "R7");
    issue(1, 4, 1, 8'h55, "R6");
    issue(0, 4, 1, 0, "R6");

    // R2: block 0 shares set 0 with block 4 but has a different tag
    issue(0, 0, 5, 0, "R2");
    issue(0, 4, 1, 0, "R2");

    // R5 / R11: three and four blocks contending for set 1
    issue(0, 1, 3, 0, "R5");
    issue(0, 5, 3, 0, "R5");
    issue(0, 9, 3, 0, "R11");
    issue(0, 1, 3, 0, "R11");
    issue(0, 5, 3, 0, "R11");
    issue(0, 1, 3, 0, "R11");
    issue(1, 13, 7, 8'h3C, "R11");
    issue(0, 9, 3, 0, "R11");
    issue(0, 13, 7, 0, "R11");

    // R6 mixed traffic over several sets
    for (int i = 0; i < 24; i++)
      issue(i % 3 == 0, (i * 5) % 16, (i * 3) % 16, 8'(i * 11 + 1), (i % 3 == 0) ? "R6" : "R3");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    // R10 counters
    check(int'(rd_hit_cnt)  == m_rh, "R10", "rd_hit_cnt",  int'(rd_hit_cnt),  m_rh);
    check(int'(rd_miss_cnt) == m_rm, "R10", "rd_miss_cnt", int'(rd_miss_cnt), m_rm);
    check(int'(wr_hit_cnt)  == m_wh, "R10", "wr_hit_cnt",  int'(wr_hit_cnt),  m_wh);
    check(int'(wr_miss_cnt) == m_wm, "R10", "wr_miss_cnt", int'(wr_miss_cnt), m_wm);
    // R6 write-through: one strobe per store, memory matches model
    check(we_seen == m_writes, "R6", "mem_we strobes", we_seen, m_writes);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== model_mem[a]) bad++;
    check(bad == 0, "R6", "memory bytes differing", bad, 0);

    summary();
    $finish;
  end
endmodule